// File: doc/BRIEF.md
# Peripheral Security and Privilege Gate

This block sits between the bus matrix and a bank of peripheral slaves. Every transfer that reaches it is checked twice: once against a per-slot secure/non-secure attribute, and once against a per-slot privileged/unprivileged attribute. A transfer that passes both checks drives exactly one slave select in its request cycle. A transfer that fails never reaches a slave select.

The two kinds of failure are handled differently. A security failure ends in a two-beat bus error. A privilege failure fails silently: a write is lost and a read returns zero, and no error is signalled. Masters that cannot signal security themselves take their security from an attribute held per master. One slot serves a GPIO bank, and its security is held per pin. A fixed group of slots is security-only. The block also holds three address/data compare pairs. Each pair raises a sticky flag when a guarded write carries unexpected data, as a hardening measure against fault injection.

The address space is split by the top SB address bits, where SB = clog2(NPERIPH+1). Slots 0 to NPERIPH-1 are peripherals. Slot NPERIPH is the gate's own register bank, and any higher slot is unmapped.

Request rules:
- A request is a valid/ready handshake. Address, write data and sideband arrive in the same cycle.
- `req_ready` drops for exactly one cycle, the first beat of a security error. Otherwise it stays high, so one request may be accepted every cycle.
- The response comes one cycle after acceptance and cannot be back-pressured.

Top module: `periph_guard`

## Requirements
- R1: After reset, every register reads as zero: all slots secure and privileged-only, all masters secure, all GPIO pins secure, and no compare flag set. `req_ready` is high and `rsp_valid` is low.
- R2: An accepted transfer that passes its checks raises only `periph_sel[slot]`, combinationally in its request cycle. Exactly one cycle later, `rsp_valid` is 1 with `rsp_err` 0. A read returns `periph_rdata` ANDed with the read mask. A secure transfer passes the security check for any slot. A non-secure transfer passes it only if the slot's bit in SECMAP is 1 (bit 1 = non-secure).
- R3: A security failure selects no slave. This covers a non-secure transfer to a secure slot, to the register bank, or to an unmapped slot. In the next cycle `rsp_err` is 1 while `rsp_valid` and `req_ready` are 0. In the cycle after that, `rsp_err` and `rsp_valid` are both 1. `req_ready` is never low at any other time.
- R4: A transfer that passes the security check but is unprivileged to a slot whose PRIVOPEN bit is 0 (bit 1 = unprivileged allowed) selects no slave. One cycle later it responds with `rsp_valid` 1, `rsp_err` 0 and read data zero. Its write is dropped.
- R5: The slots named in SEC_ONLY (default slots 0 and 1) are always secure and accept unprivileged transfers. Their SECMAP and PRIVOPEN bits read as 0 and ignore writes.
- R6: Slot GPIO_SLOT (default 2) handles per-pin security through PINMAP (bit p = 1 means pin p is non-secure). For a non-secure transfer to this slot, bit p of `periph_wmask` is cleared and bit p of the read data is forced to zero for each secure pin p. In every other case `periph_wmask` is all ones.
- R7: If `req_sec_aware` is 0, `req_nonsec` is ignored. The transfer is then non-secure exactly when MSTMAP bit `req_master` is 1.
- R8: Only a secure, privileged transfer may write or read the register bank. A non-secure access to the bank fails as in R3. A secure unprivileged access fails as in R4, so its write has no effect and its read returns zero.
- R9: Compare pair k (k = 0..2) is armed by a write to its address register. After that, any accepted write whose full address equals the armed address and whose data differs from the pair's data register sets flag bit k. Flag bit k then stays set until reset. A write with matching data, or to another address, leaves it unchanged.
- R10: Register bank word offsets are as follows. SECMAP is at 0x00, PRIVOPEN at 0x04, MSTMAP at 0x08 and PINMAP at 0x0C. Compare pair k has its address at 0x10+8k and its data at 0x14+8k. FLAGS, which is read-only, is at 0x28. Every writable field reads back what was written, masked as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | AW | Byte address; top SB bits choose the slot |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_nonsec | input | 1 | Master's own security signal, 1 = non-secure |
| req_priv | input | 1 | 1 = privileged transfer |
| req_sec_aware | input | 1 | 1 = trust req_nonsec, 0 = use MSTMAP |
| req_master | input | clog2(NMST) | Index of the issuing master |
| periph_sel | output | NPERIPH | One-hot slave select, only for passing transfers |
| periph_addr | output | AW-SB | Offset inside the selected slot |
| periph_write | output | 1 | Forwarded write flag |
| periph_wdata | output | DW | Forwarded write data |
| periph_wmask | output | DW | Bit write enables (GPIO pin protection) |
| periph_rdata | input | DW | Read data returned by the selected slave in the response cycle |
| rsp_valid | output | 1 | Response completes this cycle |
| rsp_err | output | 1 | Error response beat |
| rsp_rdata | output | DW | Read data |

## Verification
A sweep covers the eight slots and every combination of security, privilege and direction, repeated under four programmed attribute patterns. Because the patterns change which slots are open, it shows that the choice between pass, error and silent drop comes from the stored attributes and not from the slot number. The same sweep is run again with `req_sec_aware` low and `req_nonsec` set to the opposite of what each master's attribute implies. This shows that the per-master attribute is used and the sideband is ignored. Readback through the register bank shows the fixed slots refusing writes, and shows that a denied register write has no effect. A short sequence of matching, mismatching and off-address writes shows that the compare flags trip only on a data mismatch at the armed address, and stay set afterwards.

// File: rtl/periph_guard_pkg.sv
`timescale 1ns/1ps
package periph_guard_pkg;
  localparam int unsigned NCMP = 3;

  typedef enum logic [1:0] {
    VERD_PASS = 2'd0,
    VERD_SEC  = 2'd1,
    VERD_PRIV = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    DP_NONE   = 2'd0,
    DP_PERIPH = 2'd1,
    DP_CFG    = 2'd2,
    DP_ZERO   = 2'd3
  } dphase_e;
endpackage

// File: rtl/periph_guard_regs.sv
`timescale 1ns/1ps
module periph_guard_regs
  import periph_guard_pkg::*;
#(
  parameter int unsigned NPERIPH = 7,
  parameter int unsigned NMST    = 4,
  parameter int unsigned NPIN    = 8,
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 32,
  parameter logic [NPERIPH-1:0] SEC_ONLY = 7'b0000011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [5:0]         cfg_word,
  input  logic [DW-1:0]      cfg_wdata,
  input  logic               watch_we,
  input  logic [AW-1:0]      watch_addr,
  input  logic [DW-1:0]      watch_data,
  output logic [NPERIPH-1:0] sec_ns,
  output logic [NPERIPH-1:0] priv_open,
  output logic [NMST-1:0]    mst_ns,
  output logic [NPIN-1:0]    pin_ns,
  output logic [NCMP-1:0]    cmp_flag,
  output logic [DW-1:0]      cfg_rdata
);
  localparam logic [5:0] W_SEC  = 6'd0;
  localparam logic [5:0] W_PRIV = 6'd1;
  localparam logic [5:0] W_MST  = 6'd2;
  localparam logic [5:0] W_PIN  = 6'd3;
  localparam logic [5:0] W_CMP0 = 6'd4;
  localparam logic [5:0] W_FLAG = 6'd10;
  localparam logic [NPERIPH-1:0] OPEN_MASK = ~SEC_ONLY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_ns    <= '0;
      priv_open <= '0;
      mst_ns    <= '0;
      pin_ns    <= '0;
    end else if (cfg_we) begin
      case (cfg_word)
        W_SEC:   sec_ns    <= cfg_wdata[NPERIPH-1:0] & OPEN_MASK;
        W_PRIV:  priv_open <= cfg_wdata[NPERIPH-1:0] & OPEN_MASK;
        W_MST:   mst_ns    <= cfg_wdata[NMST-1:0];
        W_PIN:   pin_ns    <= cfg_wdata[NPIN-1:0];
        default: ;
      endcase
    end
  end

  logic [AW-1:0] cmp_addr [NCMP];
  logic [DW-1:0] cmp_data [NCMP];

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    localparam logic [5:0] WA = 6'(W_CMP0 + 2 * k);
    localparam logic [5:0] WD = 6'(W_CMP0 + 2 * k + 1);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          armed_q;
    logic          flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q  <= '0;
        data_q  <= '0;
        armed_q <= 1'b0;
        flag_q  <= 1'b0;
      end else begin
        if (cfg_we && cfg_word == WA) begin
          addr_q  <= cfg_wdata[AW-1:0];
          armed_q <= 1'b1;
        end
        if (cfg_we && cfg_word == WD) data_q <= cfg_wdata;
        if (armed_q && watch_we && watch_addr == addr_q && watch_data != data_q)
          flag_q <= 1'b1;
      end
    end

    assign cmp_addr[k] = addr_q;
    assign cmp_data[k] = data_q;
    assign cmp_flag[k] = flag_q;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_word)
      W_SEC:  cfg_rdata[NPERIPH-1:0] = sec_ns;
      W_PRIV: cfg_rdata[NPERIPH-1:0] = priv_open;
      W_MST:  cfg_rdata[NMST-1:0]    = mst_ns;
      W_PIN:  cfg_rdata[NPIN-1:0]    = pin_ns;
      W_FLAG: cfg_rdata[NCMP-1:0]    = cmp_flag;
      default: begin
        for (int k = 0; k < NCMP; k++) begin
          if (cfg_word == 6'(W_CMP0 + 2 * k))     cfg_rdata[AW-1:0] = cmp_addr[k];
          if (cfg_word == 6'(W_CMP0 + 2 * k + 1)) cfg_rdata         = cmp_data[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/periph_guard_check.sv
`timescale 1ns/1ps
module periph_guard_check
  import periph_guard_pkg::*;
#(
  parameter int unsigned NPERIPH = 7,
  parameter int unsigned SB      = 3,
  parameter logic [NPERIPH-1:0] SEC_ONLY = 7'b0000011
) (
  input  logic [SB-1:0]      slot,
  input  logic               ns,
  input  logic               priv,
  input  logic [NPERIPH-1:0] sec_ns,
  input  logic [NPERIPH-1:0] priv_open,
  output verdict_e           verdict,
  output logic               is_cfg
);
  localparam int unsigned NSLOT = 1 << SB;

  logic [NSLOT-1:0] sec_pad;
  logic [NSLOT-1:0] open_pad;
  logic             sec_ok;
  logic             priv_ok;

  assign sec_pad  = NSLOT'(sec_ns);
  assign open_pad = NSLOT'(priv_open | SEC_ONLY);

  always_comb begin
    is_cfg = (slot == SB'(NPERIPH));
    if (slot < SB'(NPERIPH)) begin
      sec_ok  = !ns || sec_pad[slot];
      priv_ok = priv || open_pad[slot];
    end else if (is_cfg) begin
      sec_ok  = !ns;
      priv_ok = priv;
    end else begin
      sec_ok  = 1'b0;
      priv_ok = 1'b1;
    end
    if (!sec_ok)       verdict = VERD_SEC;
    else if (!priv_ok) verdict = VERD_PRIV;
    else               verdict = VERD_PASS;
  end
endmodule

// File: rtl/periph_guard_resp.sv
`timescale 1ns/1ps
module periph_guard_resp
  import periph_guard_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  verdict_e      verdict,
  input  logic          is_cfg,
  input  logic [DW-1:0] rmask_in,
  input  logic [DW-1:0] cfg_rdata_in,
  input  logic [DW-1:0] periph_rdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  logic          err1_q;
  logic          err2_q;
  dphase_e       dp_q;
  logic [DW-1:0] rmask_q;
  logic [DW-1:0] cfgd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err1_q  <= 1'b0;
      err2_q  <= 1'b0;
      dp_q    <= DP_NONE;
      rmask_q <= '0;
      cfgd_q  <= '0;
    end else begin
      err1_q <= acc && (verdict == VERD_SEC);
      err2_q <= err1_q;
      if (!acc)                     dp_q <= DP_NONE;
      else if (verdict == VERD_PASS) dp_q <= is_cfg ? DP_CFG : DP_PERIPH;
      else if (verdict == VERD_PRIV) dp_q <= DP_ZERO;
      else                           dp_q <= DP_NONE;
      if (acc) begin
        rmask_q <= rmask_in;
        cfgd_q  <= cfg_rdata_in;
      end
    end
  end

  assign req_ready = !err1_q;
  assign rsp_valid = err2_q || (dp_q != DP_NONE);
  assign rsp_err   = err1_q || err2_q;

  always_comb begin
    case (dp_q)
      DP_PERIPH: rsp_rdata = periph_rdata & rmask_q;
      DP_CFG:    rsp_rdata = cfgd_q;
      default:   rsp_rdata = '0;
    endcase
  end
endmodule

// File: rtl/periph_guard.sv
`timescale 1ns/1ps
module periph_guard
  import periph_guard_pkg::*;
#(
  parameter int unsigned NPERIPH   = 7,
  parameter int unsigned NMST      = 4,
  parameter int unsigned NPIN      = 8,
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned GPIO_SLOT = 2,
  parameter logic [NPERIPH-1:0] SEC_ONLY = 7'b0000011,
  localparam int unsigned SB = $clog2(NPERIPH + 1),
  localparam int unsigned MW = $clog2(NMST)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  input  logic               req_write,
  input  logic [DW-1:0]      req_wdata,
  input  logic               req_nonsec,
  input  logic               req_priv,
  input  logic               req_sec_aware,
  input  logic [MW-1:0]      req_master,
  output logic [NPERIPH-1:0] periph_sel,
  output logic [AW-SB-1:0]   periph_addr,
  output logic               periph_write,
  output logic [DW-1:0]      periph_wdata,
  output logic [DW-1:0]      periph_wmask,
  input  logic [DW-1:0]      periph_rdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DW-1:0]      rsp_rdata
);
  logic [NPERIPH-1:0] sec_ns;
  logic [NPERIPH-1:0] priv_open;
  logic [NMST-1:0]    mst_ns;
  logic [NPIN-1:0]    pin_ns;
  logic [NCMP-1:0]    cmp_flag;
  logic [DW-1:0]      cfg_rdata;
  logic [SB-1:0]      slot;
  logic               eff_ns;
  logic               acc;
  logic               is_cfg;
  logic [DW-1:0]      pin_mask;
  verdict_e           verdict;

  assign acc    = req_valid && req_ready;
  assign slot   = req_addr[AW-1 -: SB];
  assign eff_ns = req_sec_aware ? req_nonsec : mst_ns[req_master];

  always_comb begin
    pin_mask = '1;
    if (eff_ns && slot == SB'(GPIO_SLOT)) pin_mask[NPIN-1:0] = pin_ns;
  end

  periph_guard_regs #(
    .NPERIPH(NPERIPH), .NMST(NMST), .NPIN(NPIN), .AW(AW), .DW(DW), .SEC_ONLY(SEC_ONLY)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (acc && is_cfg && verdict == VERD_PASS && req_write),
    .cfg_word  (req_addr[7:2]),
    .cfg_wdata (req_wdata),
    .watch_we  (acc && req_write),
    .watch_addr(req_addr),
    .watch_data(req_wdata),
    .sec_ns    (sec_ns),
    .priv_open (priv_open),
    .mst_ns    (mst_ns),
    .pin_ns    (pin_ns),
    .cmp_flag  (cmp_flag),
    .cfg_rdata (cfg_rdata)
  );

  periph_guard_check #(
    .NPERIPH(NPERIPH), .SB(SB), .SEC_ONLY(SEC_ONLY)
  ) u_check (
    .slot     (slot),
    .ns       (eff_ns),
    .priv     (req_priv),
    .sec_ns   (sec_ns),
    .priv_open(priv_open),
    .verdict  (verdict),
    .is_cfg   (is_cfg)
  );

  periph_guard_resp #(.DW(DW)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .verdict     (verdict),
    .is_cfg      (is_cfg),
    .rmask_in    (pin_mask),
    .cfg_rdata_in(cfg_rdata),
    .periph_rdata(periph_rdata),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata)
  );

  for (genvar i = 0; i < NPERIPH; i++) begin : g_sel
    assign periph_sel[i] = acc && (verdict == VERD_PASS) && (slot == SB'(i));
  end

  assign periph_addr  = req_addr[AW-SB-1:0];
  assign periph_write = req_write;
  assign periph_wdata = req_wdata;
  assign periph_wmask = pin_mask;
endmodule

// File: rtl/periph_guard_sva.sv
`timescale 1ns/1ps
module periph_guard_sva #(
  parameter int unsigned NPERIPH   = 7,
  parameter int unsigned NPIN      = 8,
  parameter int unsigned DW        = 32,
  parameter int unsigned GPIO_SLOT = 2,
  parameter int unsigned NCMP      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_nonsec,
  input logic               req_sec_aware,
  input logic [NPERIPH-1:0] periph_sel,
  input logic [DW-1:0]      periph_wmask,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [NPIN-1:0]    pin_ns,
  input logic [NCMP-1:0]    cmp_flag
);
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_sel));

  assert_sel_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_sel) |-> (req_valid && req_ready));

  assert_err_second_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && !rsp_valid) |=> (rsp_err && rsp_valid));

  assert_stall_only_on_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (rsp_err && !rsp_valid));

  assert_gpio_secure_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_sel[GPIO_SLOT] && req_sec_aware && req_nonsec)
      |-> ((periph_wmask[NPIN-1:0] & ~pin_ns) == '0));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cmp_flag) & ~cmp_flag) == '0));
endmodule

bind periph_guard periph_guard_sva #(
  .NPERIPH(NPERIPH), .NPIN(NPIN), .DW(DW), .GPIO_SLOT(GPIO_SLOT), .NCMP(periph_guard_pkg::NCMP)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_nonsec   (req_nonsec),
  .req_sec_aware(req_sec_aware),
  .periph_sel   (periph_sel),
  .periph_wmask (periph_wmask),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .pin_ns       (pin_ns),
  .cmp_flag     (cmp_flag)
);

// File: tb/periph_guard_bench.sv
`timescale 1ns/1ps
module periph_guard_bench;
  localparam logic [31:0] PR = 32'h5AC3_96F1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_nonsec = 1'b0;
  logic        req_priv = 1'b0;
  logic        req_sec_aware = 1'b1;
  logic [1:0]  req_master = '0;
  logic [6:0]  periph_sel;
  logic [12:0] periph_addr;
  logic        periph_write;
  logic [31:0] periph_wdata;
  logic [31:0] periph_wmask;
  logic [31:0] periph_rdata = PR;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  periph_guard u_periph_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_nonsec(req_nonsec), .req_priv(req_priv), .req_sec_aware(req_sec_aware),
    .req_master(req_master), .periph_sel(periph_sel), .periph_addr(periph_addr),
    .periph_write(periph_write), .periph_wdata(periph_wdata), .periph_wmask(periph_wmask),
    .periph_rdata(periph_rdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [6:0]  m_sec = '0;
  logic [6:0]  m_priv = '0;
  logic [3:0]  m_mst = '0;
  logic [7:0]  m_pin = '0;

  logic        o_rdy, rr1, r1v, r1e, r2v, r2e;
  logic [6:0]  o_sel;
  logic [31:0] o_mask, r1d;

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] a, input bit w, input logic [31:0] d,
                      input bit ns, input bit pv, input bit aw, input logic [1:0] m);
    @(negedge clk);
    req_addr = a; req_write = w; req_wdata = d; req_nonsec = ns;
    req_priv = pv; req_sec_aware = aw; req_master = m; req_valid = 1'b1;
    #1;
    o_rdy = req_ready; o_sel = periph_sel; o_mask = periph_wmask;
    @(posedge clk); #1;
    req_valid = 1'b0;
    rr1 = req_ready; r1v = rsp_valid; r1e = rsp_err; r1d = rsp_rdata;
    @(posedge clk); #1;
    r2v = rsp_valid; r2e = rsp_err;
  endtask

  task automatic cfg_wr(input int word, input logic [31:0] d);
    xfer(16'hE000 | 16'(word * 4), 1'b1, d, 1'b0, 1'b1, 1'b1, 2'd0);
  endtask

  task automatic cfg_rd_chk(input int word, input logic [31:0] exp, input string tag);
    xfer(16'hE000 | 16'(word * 4), 1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 2'd0);
    chk(r1v && !r1e && r1d == exp, tag, {32'h0, r1d}, {32'h0, exp});
  endtask

  // Expected outcome from the requirement text: 0 pass, 1 security error, 2 silent drop.
  function automatic int exp_v(input int slot, input bit ns, input bit pv);
    if (slot < 7) begin
      if (ns && !m_sec[slot]) return 1;
      if (!pv && !m_priv[slot] && slot >= 2) return 2;
      return 0;
    end
    if (ns) return 1;
    if (!pv) return 2;
    return 0;
  endfunction

  task automatic check_xfer(input int slot, input bit nsin, input bit pv, input bit w,
                            input bit aw, input int m);
    bit ns;
    int v;
    string tag;
    logic [6:0]  e_sel;
    logic [31:0] e_mask, e_rd;
    logic [4:0]  e_ctl;
    ns = aw ? nsin : m_mst[m];
    v = exp_v(slot, ns, pv);
    e_sel  = (v == 0 && slot < 7) ? 7'(1 << slot) : 7'h0;
    e_mask = (ns && slot == 2) ? {24'hFF_FFFF, m_pin} : 32'hFFFF_FFFF;
    if (v == 2)        e_rd = 32'h0;
    else if (slot < 7) e_rd = PR & e_mask;
    else               e_rd = {25'h0, m_sec};
    e_ctl = (v == 1) ? 5'b00111 : 5'b11000;
    if (!aw)                        tag = "R7";
    else if (v == 1)                tag = "R3";
    else if (v == 2)                tag = "R4";
    else if (slot == 2 && ns)       tag = "R6";
    else if (slot < 2 && !pv)       tag = "R5";
    else                            tag = "R2";
    xfer(16'({3'(slot), 13'h0}), w, 32'hDEAD_0000 | 32'(slot), nsin, pv, aw, 2'(m));
    chk({o_rdy, o_sel, o_mask} == {1'b1, e_sel, e_mask}, tag,
        {24'h0, o_rdy, o_sel, o_mask}, {24'h0, 1'b1, e_sel, e_mask});
    chk({rr1, r1v, r1e, r2v, r2e} == e_ctl && (w || v == 1 || r1d == e_rd), tag,
        {27'h0, rr1, r1v, r1e, r2v, r2e, r1d}, {27'h0, e_ctl, (w || v == 1) ? r1d : e_rd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready && !rsp_valid && !rsp_err && periph_sel == 0, "R1",
        {61'h0, req_ready, rsp_valid, rsp_err}, 64'h4);
    @(negedge clk); rst_n = 1'b1;
    // R1: every register word starts at zero
    for (int wd = 0; wd <= 10; wd++) cfg_rd_chk(wd, 32'h0, "R1");

    // R5: fixed slots refuse writes; R10 readback
    cfg_wr(0, 32'hFFFF_FFFF);
    cfg_wr(1, 32'hFFFF_FFFF);
    cfg_rd_chk(0, 32'h7C, "R5");
    cfg_rd_chk(1, 32'h7C, "R5");

    // Sweeps over four attribute patterns (R2 R3 R4 R5 R6 R10)
    for (int p = 0; p < 4; p++) begin
      m_sec  = 7'(p * 37 + 5) & 7'h7C;
      m_priv = 7'(p * 91 + 3) & 7'h7C;
      m_pin  = 8'(p * 73 + 28);
      cfg_wr(0, {25'h0, 7'(p * 37 + 5)});
      cfg_wr(1, {25'h0, 7'(p * 91 + 3)});
      cfg_wr(3, {24'h0, m_pin});
      cfg_rd_chk(0, {25'h0, m_sec}, "R10");
      cfg_rd_chk(1, {25'h0, m_priv}, "R10");
      cfg_rd_chk(3, {24'h0, m_pin}, "R10");
      for (int s = 0; s < 8; s++)
        for (int ns = 0; ns < 2; ns++)
          for (int pv = 0; pv < 2; pv++)
            for (int w = 0; w < 2; w++)
              if (s < 7 || w == 0) check_xfer(s, 1'(ns), 1'(pv), 1'(w), 1'b1, 0);
    end

    // R7: per-master attribute overrides the ignored sideband
    m_mst = 4'b1010;
    cfg_wr(2, 32'h0000_000A);
    cfg_rd_chk(2, 32'hA, "R7");
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 7; s++)
        check_xfer(s, ~m_mst[m], 1'b1, 1'b0, 1'b0, m);

    // R8: denied register accesses
    xfer(16'hE00C, 1'b1, 32'h0000_00FF, 1'b1, 1'b1, 1'b1, 2'd0);
    chk(!rr1 && r1e && r2v && r2e, "R8", {60'h0, rr1, r1e, r2v, r2e}, 64'h7);
    cfg_rd_chk(3, {24'h0, m_pin}, "R8");
    xfer(16'hE00C, 1'b1, 32'h0000_00FF, 1'b0, 1'b0, 1'b1, 2'd0);
    chk(r1v && !r1e && !r2v, "R8", {61'h0, r1v, r1e, r2v}, 64'h4);
    cfg_rd_chk(3, {24'h0, m_pin}, "R8");
    xfer(16'hE00C, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 2'd0);
    chk(r1v && !r1e && r1d == 32'h0, "R8", {31'h0, r1v, r1d}, {31'h0, 1'b1, 32'h0});
    xfer(16'hE00C, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 2'd0);
    chk(!r1v && r1e && r2v && r2e, "R8", {60'h0, r1v, r1e, r2v, r2e}, 64'h7);

    // R9: compare pairs
    cfg_wr(4, 32'h0000_6010);
    cfg_wr(5, 32'h1234_ABCD);
    cfg_wr(6, 32'h0000_4000);
    cfg_wr(7, 32'h0000_0005);
    cfg_rd_chk(4, 32'h6010, "R10");
    cfg_rd_chk(5, 32'h1234_ABCD, "R10");
    xfer(16'h6010, 1'b1, 32'h1234_ABCD, 1'b0, 1'b1, 1'b1, 2'd0);
    xfer(16'h4004, 1'b1, 32'h0000_0009, 1'b0, 1'b1, 1'b1, 2'd0);
    cfg_rd_chk(10, 32'h0, "R9");
    xfer(16'h6010, 1'b1, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 2'd0);
    cfg_rd_chk(10, 32'h1, "R9");
    xfer(16'h6010, 1'b1, 32'h1234_ABCD, 1'b0, 1'b1, 1'b1, 2'd0);
    cfg_rd_chk(10, 32'h1, "R9");
    xfer(16'h4000, 1'b1, 32'h0000_0006, 1'b1, 1'b0, 1'b1, 2'd0);
    cfg_rd_chk(10, 32'h3, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule